// File: doc/BRIEF.md
# Floppy Head Seek and Step Controller

This block runs the head-positioning commands of a floppy disk controller. A host writes a command byte. Its upper nibble picks one of five operations: return to track zero, seek to a target track, step once, step inward, or step outward. The two low bits select one of four step periods. The block holds an 8-bit track register, an 8-bit target (data) register and a latched step direction.

While a command runs, the block drives the drive's step and direction lines and watches the drive's track-zero input. At the end it drops busy and raises an interrupt request. A seek moves the head one pulse per step period until the track register equals the target. A return to track zero is handled as a seek to zero from an assumed track of 255. It finishes early when the drive reports track zero while moving outward.

Step periods are counted in ticks of an internal prescaler. The number of clocks per tick and the tick count for each of the four period codes are parameters. After reset the block runs a return to track zero with period code 3.

Top module: `fdc_seek_ctrl`

## Requirements
- R1: Command bytes with bit 7 clear are accepted. Upper nibble 0 means return to zero, 1 means seek, 2/3 means step, 4/5 means step inward and 6/7 means step outward. A command byte with bit 7 set has no effect: busy, irq, the track and data registers and the step line do not change.
- R2: Return to zero loads 255 into the track register and 0 into the data register, then behaves as a seek. On a drive whose head ends at track zero, it finishes with the track register at 0.
- R3: A seek whose track register already equals the data register ends without a step pulse. Otherwise the direction is set inward (step_dir = 1) when data > track and outward otherwise. The block steps until the two are equal, moving the track register by one per pulse.
- R4: A step pulse changes the track register by +1 (inward) or -1 (outward) only for return to zero, seek, or a step command with bit 4 set. A step command with bit 4 clear leaves the track register unchanged.
- R5: When the direction is outward and trk0_in is high at a step decision, no pulse is issued, the track register is forced to 0 and the command ends.
- R6: Command bits [1:0] = n select RATEn ticks of TICK_DIV clocks each. During a seek, consecutive step pulses are RATEn*TICK_DIV+3 clocks apart. A step pulse is one clock wide.
- R7: Step inward and step outward latch the direction. A plain step (nibble 2/3) issues exactly one pulse in the last latched direction. status_q bit 1 shows the latched direction (1 = inward).
- R8: status_q bit 0 (busy) is high from the clock after an accepted command until completion. At completion busy clears and irq rises. Accepting a command clears irq.
- R9: Pulsing stat_rd while irq is high clears irq.
- R10: An accepted command written while busy abandons the running sequence and starts the new one.
- R11: Reset leaves busy high, the track register at 255, the data register at 0 and the direction inward. It then runs a return to zero with period code 3.
- R12: Writes to the track or data register while busy are ignored. While idle they load the register. status_q bit 2 reflects trk0_in one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command byte write strobe |
| cmd_byte | input | 8 | Command byte |
| trk_wr | input | 1 | Track register write strobe |
| trk_wdata | input | 8 | Track register write value |
| dat_wr | input | 1 | Data (target) register write strobe |
| dat_wdata | input | 8 | Data register write value |
| stat_rd | input | 1 | Status read strobe, clears irq |
| trk0_in | input | 1 | Drive reports head at track zero |
| step_pulse | output | 1 | One-clock step pulse to the drive |
| step_dir | output | 1 | Step direction, 1 = inward |
| track_q | output | 8 | Track register |
| data_q | output | 8 | Data register |
| status_q | output | 8 | {5'b0, track-zero, direction, busy} |
| irq | output | 1 | Interrupt request |

## Verification
The bench models a drive head position that answers trk0_in. It runs seeks inward and outward, seeks to the current track, and each step variant with and without the update bit. This separates the track-register update rule from the pulse count. Stepping outward into track zero shows the forced-zero stop. Every period code is swept, and the measured pulse spacing separates the four period selections. A restart during a running seek, register writes during busy and high-nibble commands show which inputs are honoured and which are dropped.

// File: rtl/fdc_seek_pkg.sv
package fdc_seek_pkg;

  typedef enum logic [2:0] {
    OP_HOME,
    OP_SEEK,
    OP_STEP,
    OP_STEP_IN,
    OP_STEP_OUT
  } seek_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EVAL,
    ST_STEP,
    ST_WAIT
  } seq_state_e;

  function automatic logic op_is_seek(input seek_op_e op);
    return (op == OP_HOME) || (op == OP_SEEK);
  endfunction

endpackage

// File: rtl/fdc_seek_decode.sv
module fdc_seek_decode
  import fdc_seek_pkg::*;
(
  input  logic [7:0] cmd_byte,
  output logic       hit,
  output seek_op_e   op,
  output logic       upd,
  output logic [1:0] rate
);

  logic [3:0] nib;
  logic       unused_opt;

  assign nib        = cmd_byte[7:4];
  assign unused_opt = ^cmd_byte[3:2];
  assign hit        = ~cmd_byte[7];
  assign rate       = cmd_byte[1:0];

  always_comb begin
    unique case (nib[2:1])
      2'd0:    op = nib[0] ? OP_SEEK : OP_HOME;
      2'd1:    op = OP_STEP;
      2'd2:    op = OP_STEP_IN;
      default: op = OP_STEP_OUT;
    endcase
  end

  // positioning to a target always tracks; single steps only with bit 4
  assign upd = (nib[2:1] == 2'd0) | cmd_byte[4];

endmodule

// File: rtl/fdc_step_timer.sv
module fdc_step_timer #(
  parameter int unsigned TICK_DIV = 1000,
  parameter int unsigned RATE0    = 6,
  parameter int unsigned RATE1    = 12,
  parameter int unsigned RATE2    = 20,
  parameter int unsigned RATE3    = 30
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] rate_sel,
  output logic       done
);

  localparam int unsigned MAX01 = (RATE0 > RATE1) ? RATE0 : RATE1;
  localparam int unsigned MAX23 = (RATE2 > RATE3) ? RATE2 : RATE3;
  localparam int unsigned MAXR  = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int TW = $clog2(MAXR + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre;
  logic [TW-1:0] ticks;
  logic [TW-1:0] limit;
  logic          run;

  always_comb begin
    unique case (rate_sel)
      2'd0:    limit = TW'(RATE0);
      2'd1:    limit = TW'(RATE1);
      2'd2:    limit = TW'(RATE2);
      default: limit = TW'(RATE3);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre   <= '0;
      ticks <= '0;
      run   <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        pre   <= '0;
        ticks <= '0;
        run   <= 1'b1;
      end else if (run) begin
        if (pre == PRE_LAST) begin
          pre   <= '0;
          ticks <= ticks + TW'(1);
          if ((ticks + TW'(1)) == limit) begin
            run  <= 1'b0;
            done <= 1'b1;
          end
        end else begin
          pre <= pre + PW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/fdc_seek_seq.sv
module fdc_seek_seq
  import fdc_seek_pkg::*;
#(
  parameter int TRK_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr,
  input  logic             dec_hit,
  input  seek_op_e         dec_op,
  input  logic             dec_upd,
  input  logic [1:0]       dec_rate,
  input  logic             trk_wr,
  input  logic [TRK_W-1:0] trk_wdata,
  input  logic             dat_wr,
  input  logic [TRK_W-1:0] dat_wdata,
  input  logic             stat_rd,
  input  logic             trk0_in,
  input  logic             tmr_done,
  output logic             tmr_start,
  output logic [1:0]       rate_q,
  output logic             pulse_q,
  output logic             dir_q,
  output logic [TRK_W-1:0] track_q,
  output logic [TRK_W-1:0] data_q,
  output logic             busy_q,
  output logic             irq_q
);

  seq_state_e st;
  seek_op_e   op_q;
  logic       upd_q;
  logic       launch;
  logic       at_stop;
  logic       end_now;
  logic       seek_like;

  assign launch    = cmd_wr & dec_hit;
  assign seek_like = op_is_seek(op_q);
  assign at_stop   = (st == ST_STEP) && !dir_q && trk0_in;
  assign tmr_start = !launch && (st == ST_STEP) && !at_stop;
  assign end_now   = !launch &&
                     (((st == ST_EVAL) && (track_q == data_q)) ||
                      at_stop ||
                      ((st == ST_WAIT) && tmr_done && !seek_like));

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_EVAL;
      op_q    <= OP_HOME;
      upd_q   <= 1'b1;
      rate_q  <= 2'd3;
      pulse_q <= 1'b0;
      dir_q   <= 1'b1;
      track_q <= '1;
      data_q  <= '0;
      busy_q  <= 1'b1;
    end else begin
      pulse_q <= 1'b0;
      if (launch) begin
        op_q   <= dec_op;
        upd_q  <= dec_upd;
        rate_q <= dec_rate;
        busy_q <= 1'b1;
        unique case (dec_op)
          OP_HOME: begin
            track_q <= '1;
            data_q  <= '0;
            st      <= ST_EVAL;
          end
          OP_SEEK:     st <= ST_EVAL;
          OP_STEP_IN:  begin dir_q <= 1'b1; st <= ST_STEP; end
          OP_STEP_OUT: begin dir_q <= 1'b0; st <= ST_STEP; end
          default:     st <= ST_STEP;
        endcase
      end else begin
        unique case (st)
          ST_IDLE: begin
            if (trk_wr) track_q <= trk_wdata;
            if (dat_wr) data_q  <= dat_wdata;
          end
          ST_EVAL: begin
            if (track_q == data_q) begin
              st     <= ST_IDLE;
              busy_q <= 1'b0;
            end else begin
              dir_q <= (data_q > track_q);
              st    <= ST_STEP;
            end
          end
          ST_STEP: begin
            if (at_stop) begin
              track_q <= '0;
              st      <= ST_IDLE;
              busy_q  <= 1'b0;
            end else begin
              pulse_q <= 1'b1;
              if (upd_q) track_q <= dir_q ? track_q + TRK_W'(1) : track_q - TRK_W'(1);
              st <= ST_WAIT;
            end
          end
          default: begin
            if (tmr_done) begin
              if (seek_like) begin
                st <= ST_EVAL;
              end else begin
                st     <= ST_IDLE;
                busy_q <= 1'b0;
              end
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    irq_q <= 1'b0;
    else if (end_now)           irq_q <= 1'b1;
    else if (launch || stat_rd) irq_q <= 1'b0;
  end

endmodule

// File: rtl/fdc_seek_ctrl.sv
module fdc_seek_ctrl
  import fdc_seek_pkg::*;
#(
  parameter int unsigned TICK_DIV = 1000,
  parameter int unsigned RATE0    = 6,
  parameter int unsigned RATE1    = 12,
  parameter int unsigned RATE2    = 20,
  parameter int unsigned RATE3    = 30
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_wr,
  input  logic [7:0] cmd_byte,
  input  logic       trk_wr,
  input  logic [7:0] trk_wdata,
  input  logic       dat_wr,
  input  logic [7:0] dat_wdata,
  input  logic       stat_rd,
  input  logic       trk0_in,
  output logic       step_pulse,
  output logic       step_dir,
  output logic [7:0] track_q,
  output logic [7:0] data_q,
  output logic [7:0] status_q,
  output logic       irq
);

  localparam int TRK_W = 8;

  logic       dec_hit;
  seek_op_e   dec_op;
  logic       dec_upd;
  logic [1:0] dec_rate;
  logic       tmr_start;
  logic       tmr_done;
  logic [1:0] rate_q;
  logic       busy_q;
  logic       trk0_q;

  fdc_seek_decode u_dec (
    .cmd_byte (cmd_byte),
    .hit      (dec_hit),
    .op       (dec_op),
    .upd      (dec_upd),
    .rate     (dec_rate)
  );

  fdc_seek_seq #(.TRK_W(TRK_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd_wr    (cmd_wr),
    .dec_hit   (dec_hit),
    .dec_op    (dec_op),
    .dec_upd   (dec_upd),
    .dec_rate  (dec_rate),
    .trk_wr    (trk_wr),
    .trk_wdata (trk_wdata),
    .dat_wr    (dat_wr),
    .dat_wdata (dat_wdata),
    .stat_rd   (stat_rd),
    .trk0_in   (trk0_in),
    .tmr_done  (tmr_done),
    .tmr_start (tmr_start),
    .rate_q    (rate_q),
    .pulse_q   (step_pulse),
    .dir_q     (step_dir),
    .track_q   (track_q),
    .data_q    (data_q),
    .busy_q    (busy_q),
    .irq_q     (irq)
  );

  fdc_step_timer #(
    .TICK_DIV (TICK_DIV),
    .RATE0    (RATE0),
    .RATE1    (RATE1),
    .RATE2    (RATE2),
    .RATE3    (RATE3)
  ) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .start    (tmr_start),
    .rate_sel (rate_q),
    .done     (tmr_done)
  );

  always_ff @(posedge clk) begin
    if (rst) trk0_q <= 1'b0;
    else     trk0_q <= trk0_in;
  end

  assign status_q = {5'b0, trk0_q, step_dir, busy_q};

endmodule

// File: rtl/fdc_seek_chk.sv
module fdc_seek_chk (
  input logic       clk,
  input logic       rst,
  input logic       step_pulse,
  input logic       step_dir,
  input logic       trk0_in,
  input logic [7:0] track_q,
  input logic       busy,
  input logic       irq
);

  AST_PULSE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    step_pulse |-> busy); // R8

  AST_IRQ_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    irq |-> !busy); // R8

  AST_NO_OUT_PULSE_AT_TRK0: assert property (@(posedge clk) disable iff (rst)
    (step_pulse && !step_dir) |-> !$past(trk0_in)); // R5

  AST_PULSE_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    step_pulse |=> !step_pulse); // R6

  AST_TRACK_INWARD: assert property (@(posedge clk) disable iff (rst)
    (step_pulse && step_dir) |->
      ((track_q == $past(track_q) + 8'd1) || (track_q == $past(track_q)))); // R4

  AST_TRACK_OUTWARD: assert property (@(posedge clk) disable iff (rst)
    (step_pulse && !step_dir) |->
      ((track_q == $past(track_q) - 8'd1) || (track_q == $past(track_q)))); // R4

endmodule

bind fdc_seek_ctrl fdc_seek_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .step_pulse (step_pulse),
  .step_dir   (step_dir),
  .trk0_in    (trk0_in),
  .track_q    (track_q),
  .busy       (status_q[0]),
  .irq        (irq)
);

// File: tb/sim_fdc_seek_ctrl.sv
`timescale 1ns/1ps
module sim_fdc_seek_ctrl;

  localparam int DIV = 2;
  localparam int RT0 = 2, RT1 = 3, RT2 = 5, RT3 = 7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_wr = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic       trk_wr = 1'b0;
  logic [7:0] trk_wdata = 8'h00;
  logic       dat_wr = 1'b0;
  logic [7:0] dat_wdata = 8'h00;
  logic       stat_rd = 1'b0;
  logic       trk0_in;
  logic       step_pulse, step_dir, irq;
  logic [7:0] track_q, data_q, status_q;

  int head = 3;
  int n_pulses = 0;
  int last_cyc = 0;
  int interval = 0;
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  assign trk0_in = (head == 0);

  fdc_seek_ctrl #(.TICK_DIV(DIV), .RATE0(RT0), .RATE1(RT1), .RATE2(RT2), .RATE3(RT3)) u0 (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
    .trk_wr(trk_wr), .trk_wdata(trk_wdata), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
    .stat_rd(stat_rd), .trk0_in(trk0_in), .step_pulse(step_pulse), .step_dir(step_dir),
    .track_q(track_q), .data_q(data_q), .status_q(status_q), .irq(irq)
  );

  // drive head model
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (step_pulse) begin
      if (n_pulses > 0) interval <= cyc - last_cyc;
      last_cyc <= cyc;
      n_pulses <= n_pulses + 1;
      if (step_dir) head <= head + 1;
      else if (head > 0) head <= head - 1;
    end
  end

  function automatic int rate_of(input int r);
    case (r)
      0: return RT0;
      1: return RT1;
      2: return RT2;
      default: return RT3;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  task automatic clr_count;
    n_pulses = 0;
    interval = 0;
  endtask

  task automatic send_cmd(input logic [7:0] b);
    @(negedge clk);
    cmd_byte = b;
    cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic wait_idle;
    int t = 0;
    while (status_q[0] && t < 5000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 5000) chk("R8 timeout", 1, 0);
    @(negedge clk);
  endtask

  task automatic set_trk(input logic [7:0] v);
    @(negedge clk); trk_wr = 1'b1; trk_wdata = v;
    @(negedge clk); trk_wr = 1'b0;
  endtask

  task automatic set_dat(input logic [7:0] v);
    @(negedge clk); dat_wr = 1'b1; dat_wdata = v;
    @(negedge clk); dat_wr = 1'b0;
  endtask

  task automatic read_stat;
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic run_cmd(input logic [7:0] b);
    clr_count();
    send_cmd(b);
    wait_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog", 1, 0);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R11 reset state, before the first active edge
    chk("R11 busy", status_q[0], 1);
    chk("R11 track", track_q, 255);
    chk("R11 data", data_q, 0);
    chk("R11 dir", step_dir, 1);
    wait_idle();
    chk("R11 restore pulses", n_pulses, 3);
    chk("R11 rate3 spacing", interval, RT3 * DIV + 3);
    chk("R2 track zero", track_q, 0);
    chk("R2 head", head, 0);
    chk("R8 irq at end", irq, 1);
    chk("R12 trk0 status", status_q[2], 1);
    read_stat();
    chk("R9 irq cleared", irq, 0);

    // R3 inward seek
    set_dat(8'd5);
    clr_count();
    send_cmd(8'h10);
    chk("R8 busy after start", status_q[0], 1);
    wait_idle();
    chk("R3 seek in pulses", n_pulses, 5);
    chk("R3 seek in track", track_q, 5);
    chk("R3 dir in", step_dir, 1);
    chk("R6 rate0 spacing", interval, RT0 * DIV + 3);
    chk("R12 trk0 status low", status_q[2], 0);

    // R3 seek to same track, R8 irq cleared at start then set
    run_cmd(8'h11);
    chk("R3 equal no pulse", n_pulses, 0);
    chk("R3 equal irq", irq, 1);
    chk("R3 equal track", track_q, 5);

    // R3 outward seek
    set_dat(8'd2);
    run_cmd(8'h12);
    chk("R3 seek out pulses", n_pulses, 3);
    chk("R3 seek out head", head, 2);
    chk("R3 dir out", status_q[1], 0);
    chk("R6 rate2 spacing", interval, RT2 * DIV + 3);

    // R4 / R7 step variants
    run_cmd(8'h40);
    chk("R7 step-in pulses", n_pulses, 1);
    chk("R4 no update track", track_q, 2);
    chk("R7 step-in dir", status_q[1], 1);
    run_cmd(8'h50);
    chk("R4 update track", track_q, 3);
    run_cmd(8'h30);
    chk("R7 plain step reuses in", head, 5);
    chk("R4 plain step update", track_q, 4);
    run_cmd(8'h70);
    chk("R7 step-out dir", status_q[1], 0);
    chk("R4 step-out update", track_q, 3);
    run_cmd(8'h20);
    chk("R7 plain step reuses out", head, 3);
    chk("R4 plain no update", track_q, 3);

    // R5 outward into track zero
    set_trk(8'd9);
    chk("R12 idle track write", track_q, 9);
    for (int i = 0; i < 3; i++) run_cmd(8'h60);
    chk("R5 head at zero", head, 0);
    chk("R4 track untouched", track_q, 9);
    run_cmd(8'h60);
    chk("R5 no pulse", n_pulses, 0);
    chk("R5 forced zero", track_q, 0);
    chk("R5 irq", irq, 1);

    // R1 ignored commands
    set_dat(8'd6);
    clr_count();
    send_cmd(8'h80);
    repeat (3) @(negedge clk);
    chk("R1 ignored busy", status_q[0], 0);
    chk("R1 ignored irq", irq, 1);
    chk("R1 ignored pulse", n_pulses, 0);
    chk("R1 ignored data", data_q, 6);
    send_cmd(8'hD3);
    repeat (3) @(negedge clk);
    chk("R1 ignored busy2", status_q[0], 0);
    chk("R1 ignored track", track_q, 0);

    // R12 writes while busy
    set_dat(8'd4);
    clr_count();
    send_cmd(8'h13);
    @(negedge clk); trk_wr = 1'b1; trk_wdata = 8'h55; dat_wr = 1'b1; dat_wdata = 8'h77;
    @(negedge clk); trk_wr = 1'b0; dat_wr = 1'b0;
    wait_idle();
    chk("R12 busy track write dropped", track_q, 4);
    chk("R12 busy data write dropped", data_q, 4);
    chk("R12 head", head, 4);

    // R10 abort: restart with return to zero
    set_dat(8'd9);
    clr_count();
    send_cmd(8'h13);
    while (n_pulses < 1) @(negedge clk);
    send_cmd(8'h03);
    chk("R10 restart busy", status_q[0], 1);
    chk("R10 restart track", track_q, 255);
    wait_idle();
    chk("R10 head home", head, 0);
    chk("R10 track", track_q, 0);
    chk("R10 data", data_q, 0);

    // R6 sweep over period codes
    for (int r = 0; r < 4; r++) begin
      set_dat(8'd2);
      run_cmd(8'h10 | 8'(r));
      chk("R6 sweep spacing", interval, rate_of(r) * DIV + 3);
      chk("R6 sweep track", track_q, 2);
      set_dat(8'd0);
      run_cmd(8'h10 | 8'(r));
      chk("R6 sweep back", head, 0);
    end

    summary();
  end

endmodule